// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital controller of a four-hold, eight-input acquisition converter. A host programs, through a write strobe and a 4-bit configuration nibble, how many channels each sample converts (one to four) and which of the two input banks feeds the holds. A rising edge on the convert-start input freezes all holds at once. The controller then gives each programmed channel a fixed conversion slot, in channel order starting from channel 1, and takes a 14-bit result from a behavioural SAR port at the end of each slot.

Results are collected in a working buffer and moved as one set into a four-word result memory when the last slot ends. At that moment the holds return to tracking and the active-low interrupt falls. The host reads the words back with an active-low read strobe. The memory is sequential: the first read after a sequence gives channel 1, and later reads step through the programmed channels and wrap back to channel 1. The read path is host-paced and has no back-pressure. Each accepted strobe produces exactly one word, one clock later, and the word stays on `rd_data` until the next accepted strobe. The SAR port likewise cannot stall: `sar_data` must be valid in every cycle where `sar_take` is high.

Top module: `conv_seq_top`

## Requirements
- R1: After reset `int_n` is high, `hold` is low, `rd_data` is zero, and the mode is one channel from bank A.
- R2: A rising edge of `wr_n` sampled while `cs_n` is low loads the mode from `cfg_nib`. In this encoding bits [1:0] hold the channel count minus one and bit 2 selects the bank (0 = A, 1 = B). A nibble with bit 3 set, and any write edge while `cs_n` is high, leaves the mode unchanged.
- R3: The mode applies to every later sequence until a new valid write arrives.
- R4: The clock edge that samples a rising edge on `conv_start` raises `hold`. `hold` stays high for exactly SLOT_CYC × N cycles, where N is the channel count. `int_n` falls, and `hold` falls, on the same edge.
- R5: Rising edges on `conv_start` while `hold` is high are ignored. They neither restart nor lengthen the running sequence.
- R6: Slot k (k = 0 for channel 1) drives `sar_ch` = k and `sar_bank` = the bank of the running sequence. `sar_data` is captured in the last cycle of the slot, when `sar_take` is high.
- R7: A falling edge of `rd_n` sampled while `cs_n` is low places a stored word on `rd_data` one clock later. The first read after completion returns channel 1. Later reads return the following channels and wrap to channel 1 after channel N. `cs_n` may stay low across reads.
- R8: `int_n` returns high on the first accepted read after completion, and also when a new sequence starts.
- R9: Reads during a running sequence return the previous sequence's results, with the previous count, and do not change the new results. The first read after the new sequence completes returns its channel 1.
- R10: A read strobe while `cs_n` is high changes neither `rd_data` nor the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a slot of SLOT_CYC cycles is one conversion |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select for reads and writes |
| wr_n | input | 1 | Active-low write strobe; its rising edge loads the mode |
| rd_n | input | 1 | Active-low read strobe; its falling edge fetches a word |
| cfg_nib | input | 4 | Mode nibble: [1:0] count-1, [2] bank, [3] must be 0 |
| conv_start | input | 1 | Rising edge starts a sampling sequence |
| int_n | output | 1 | Active-low completion interrupt |
| hold | output | 1 | High while the holds are frozen and the sequence runs |
| sar_ch | output | 2 | Channel index of the current slot |
| sar_bank | output | 1 | Bank of the running sequence |
| sar_take | output | 1 | High in the cycle in which `sar_data` is captured |
| sar_data | input | 14 | Result offered by the behavioural SAR |
| rd_data | output | 14 | Word returned by the last accepted read |

## Verification
The bench goes after the edges of the sequence length. If the slot counter were off by one, `int_n` would fall a cycle early or late, so the bench samples it in the cycle before and the cycle after the expected edge. A second `conv_start` edge in the middle of a run would push the interrupt out or restart the slot order in a design that did not ignore it. A read during a run would return partly overwritten words, or leave the pointer mid-list, in a design without a separate working buffer. The bench also checks read wrap at counts one, three and four. It checks a reserved nibble and a deselected write, either of which a loose decoder would accept as a new mode, and a deselected read strobe, which a careless design would let advance the pointer.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  // channel count is fixed by the two-bit count field of the mode nibble
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef struct packed {
    logic            bank;  // 0 = bank A, 1 = bank B
    logic [CH_W-1:0] last;  // channel count minus one
  } seq_cfg_t;

  localparam seq_cfg_t CFG_RESET = '{bank: 1'b0, last: '0};

  function automatic logic nib_valid(input logic [3:0] nib);
    return ~nib[3];
  endfunction

  function automatic seq_cfg_t nib_decode(input logic [3:0] nib);
    seq_cfg_t c;
    c.bank = nib[2];
    c.last = nib[CH_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/csq_host_if.sv
module csq_host_if
  import conv_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     wr_n,
  input  logic     rd_n,
  input  logic     conv_start,
  input  logic [3:0] cfg_nib,
  output seq_cfg_t cfg,
  output logic     start_pulse,
  output logic     rd_pulse
);
  logic wr_q, rd_q, cv_q;
  logic wr_rise;

  assign wr_rise     = wr_n & ~wr_q;
  assign rd_pulse    = ~rd_n & rd_q & ~cs_n;
  assign start_pulse = conv_start & ~cv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
      cv_q <= 1'b0;
      cfg  <= CFG_RESET;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      cv_q <= conv_start;
      if (wr_rise && !cs_n && nib_valid(cfg_nib))
        cfg <= nib_decode(cfg_nib);
    end
  end
endmodule

// File: rtl/csq_seq_ctrl.sv
module csq_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int SLOT_CYC = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_pulse,
  input  logic            rd_pulse,
  input  seq_cfg_t        cfg,
  output logic            busy,
  output logic [CH_W-1:0] slot,
  output logic [CH_W-1:0] run_last,
  output logic            bank_run,
  output logic            take,
  output logic            done,
  output logic            int_n
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          last_cyc;

  assign last_cyc = (cnt == CNT_END);
  assign take     = busy & last_cyc;
  assign done     = take & (slot == run_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      slot     <= '0;
      run_last <= '0;
      bank_run <= 1'b0;
      int_n    <= 1'b1;
    end else if (!busy) begin
      if (start_pulse) begin
        busy     <= 1'b1;
        cnt      <= '0;
        slot     <= '0;
        run_last <= cfg.last;
        bank_run <= cfg.bank;
        int_n    <= 1'b1;
      end else if (rd_pulse) begin
        int_n <= 1'b1;
      end
    end else if (last_cyc) begin
      cnt <= '0;
      if (slot == run_last) begin
        busy  <= 1'b0;
        int_n <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csq_result_store.sv
module csq_result_store
  import conv_seq_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              done,
  input  logic              busy,
  input  logic              start_pulse,
  input  logic              rd_pulse,
  input  logic [CH_W-1:0]   slot,
  input  logic [CH_W-1:0]   run_last,
  input  logic [DATA_W-1:0] sar_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] work [NUM_CH];
  logic [DATA_W-1:0] mem  [NUM_CH];
  logic [CH_W-1:0]   ptr;
  logic [CH_W-1:0]   vis_last;

  // working buffer fills slot by slot; the whole set is committed at completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        work[i] <= '0;
        mem[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (take && slot == CH_W'(i)) work[i] <= sar_data;
        if (done) mem[i] <= (slot == CH_W'(i)) ? sar_data : work[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      vis_last <= '0;
      rd_data  <= '0;
    end else begin
      if (done) vis_last <= run_last;
      if (rd_pulse) begin
        rd_data <= mem[ptr];
        ptr     <= (ptr == vis_last) ? '0 : ptr + 1'b1;
      end
      if ((start_pulse && !busy) || done) ptr <= '0;
    end
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import conv_seq_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int SLOT_CYC = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [3:0]        cfg_nib,
  input  logic              conv_start,
  output logic              int_n,
  output logic              hold,
  output logic [1:0]        sar_ch,
  output logic              sar_bank,
  output logic              sar_take,
  input  logic [DATA_W-1:0] sar_data,
  output logic [DATA_W-1:0] rd_data
);
  seq_cfg_t        cfg;
  logic            start_pulse, rd_pulse;
  logic            busy, take, done, bank_run;
  logic [CH_W-1:0] slot, run_last;

  csq_host_if u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .conv_start(conv_start), .cfg_nib(cfg_nib), .cfg(cfg),
    .start_pulse(start_pulse), .rd_pulse(rd_pulse)
  );

  csq_seq_ctrl #(.SLOT_CYC(SLOT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .rd_pulse(rd_pulse),
    .cfg(cfg), .busy(busy), .slot(slot), .run_last(run_last),
    .bank_run(bank_run), .take(take), .done(done), .int_n(int_n)
  );

  csq_result_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .done(done), .busy(busy),
    .start_pulse(start_pulse), .rd_pulse(rd_pulse), .slot(slot),
    .run_last(run_last), .sar_data(sar_data), .rd_data(rd_data)
  );

  assign hold     = busy;
  assign sar_ch   = slot;
  assign sar_bank = bank_run;
  assign sar_take = take;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_n,
  input logic       hold,
  input logic       sar_take,
  input logic [1:0] sar_ch,
  input logic [1:0] run_last,
  input logic       start_pulse
);
  a_r4_hold_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(start_pulse));
  a_r4_int_fall_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (!hold && $past(hold)));
  a_r8_int_high_while_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> int_n);
  a_r6_take_inside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sar_take |-> hold);
  a_r6_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (sar_ch <= run_last));
  a_r6_take_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    sar_take |=> !sar_take);
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && start_pulse && !sar_take) |=> (hold && $stable(sar_ch)));
endmodule

bind conv_seq_top conv_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .int_n(int_n), .hold(hold), .sar_take(sar_take),
  .sar_ch(sar_ch), .run_last(run_last), .start_pulse(start_pulse)
);

// File: tb/conv_seq_top_tb_top.sv
`timescale 1ns/1ps
module conv_seq_top_tb_top;
  localparam int SC = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, conv_start = 1'b0;
  logic [3:0]  cfg_nib = 4'h0;
  logic        int_n, hold, sar_bank, sar_take;
  logic [1:0]  sar_ch;
  logic [13:0] sar_data, rd_data;
  logic [10:0] seed = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  // behavioural SAR: word encodes bank, channel and a per-run seed
  assign sar_data = {sar_bank, sar_ch, seed};

  conv_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cfg_nib(cfg_nib), .conv_start(conv_start), .int_n(int_n), .hold(hold),
    .sar_ch(sar_ch), .sar_bank(sar_bank), .sar_take(sar_take),
    .sar_data(sar_data), .rd_data(rd_data)
  );

  function automatic logic [13:0] ev(input logic [10:0] s, input int ch, input logic b);
    return {b, 2'(ch), s};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accepted read strobe
  initial begin
    logic prev = 1'b1;
    bit fire;
    forever begin
      @(posedge clk);
      fire = prev && !rd_n && !cs_n;
      prev = rd_n;
      if (fire) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk(0, "R7 unexpected read", rd_data, 0);
        else begin
          logic [13:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
    end
  end

  task automatic wr_cfg(input logic [3:0] nib, input bit sel);
    @(negedge clk); cs_n = ~sel; cfg_nib = nib; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic rd_word(input logic [13:0] e, input string req);
    @(negedge clk); cs_n = 0; rd_n = 0;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); rd_n = 1;
  endtask

  // one sequence: start, optional mid-run start edge, optional two mid-run reads
  task automatic run_seq(input int n, input logic [10:0] sd, input int dbl_at,
                         input int rd_at, input logic [10:0] pv_sd, input logic pv_b);
    seed = sd;
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    chk(hold == 1, "R4 hold high after start", hold, 1);
    for (int i = 1; i < SC * n; i++) begin
      @(negedge clk);
      if (dbl_at > 0 && i == dbl_at) conv_start = 1;
      if (dbl_at > 0 && i == dbl_at + 1) conv_start = 0;
      if (rd_at > 0 && i == rd_at) begin
        cs_n = 0; rd_n = 0; exp_q.push_back(ev(pv_sd, 0, pv_b)); tag_q.push_back("R9 busy read ch1");
      end
      if (rd_at > 0 && (i == rd_at + 1 || i == rd_at + 6)) rd_n = 1;
      if (rd_at > 0 && i == rd_at + 5) begin
        rd_n = 0; exp_q.push_back(ev(pv_sd, 1, pv_b)); tag_q.push_back("R9 busy read ch2");
      end
      if (rd_at > 0 && i == rd_at + 7) cs_n = 1;
    end
    chk(int_n == 1 && hold == 1, "R4 still running one cycle before end", {int_n, hold}, 2'b11);
    @(negedge clk);
    chk(int_n == 0 && hold == 0, "R4 int_n falls at end", {int_n, hold}, 2'b00);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int_n == 1, "R1 int_n after reset", int_n, 1);
    chk(hold == 0, "R1 hold after reset", hold, 0);
    chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);

    // R1 default one channel bank A; R7 wrap at one
    run_seq(1, 11'h0A1, 0, 0, 0, 0);
    rd_word(ev(11'h0A1, 0, 0), "R1 default ch1");
    @(negedge clk);
    chk(int_n == 1, "R8 int_n high after first read", int_n, 1);
    rd_word(ev(11'h0A1, 0, 0), "R7 wrap count 1");
    rd_word(ev(11'h0A1, 0, 0), "R7 wrap count 1 again");

    // R2 four channels bank A
    wr_cfg(4'b0011, 1);
    run_seq(4, 11'h2B2, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) rd_word(ev(11'h2B2, k % 4, 0), "R7 four-channel order");

    // R3 mode persists
    run_seq(4, 11'h3C3, 0, 0, 0, 0);
    rd_word(ev(11'h3C3, 0, 0), "R3 persist ch1");
    rd_word(ev(11'h3C3, 1, 0), "R3 persist ch2");

    // R2 bank B three channels
    wr_cfg(4'b0110, 1);
    run_seq(3, 11'h4D4, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) rd_word(ev(11'h4D4, k % 3, 1), "R2 bank B order");

    // R2 reserved nibble and deselected write ignored
    wr_cfg(4'b1001, 1);
    wr_cfg(4'b0000, 0);
    run_seq(3, 11'h5E5, 0, 0, 0, 0);
    rd_word(ev(11'h5E5, 0, 1), "R2 ignored writes ch1");

    // R10 deselected read strobe
    @(negedge clk); cs_n = 1; rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk(rd_data == ev(11'h5E5, 0, 1), "R10 rd_data unchanged", rd_data, ev(11'h5E5, 0, 1));
    rd_word(ev(11'h5E5, 1, 1), "R10 pointer unmoved");

    // R5 second start edge during run
    run_seq(3, 11'h6F6, 60, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk(hold == 0, "R5 no restart after ignored edge", hold, 0);
    rd_word(ev(11'h6F6, 0, 1), "R6 slot capture ch1");
    rd_word(ev(11'h6F6, 1, 1), "R6 slot capture ch2");
    rd_word(ev(11'h6F6, 2, 1), "R6 slot capture ch3");

    // R9 reads during run return previous set
    wr_cfg(4'b0001, 1);
    run_seq(2, 11'h707, 0, 10, 11'h6F6, 1);
    for (int k = 0; k < 3; k++) rd_word(ev(11'h707, k % 2, 0), "R9 new set after run");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule